// File: doc/BRIEF.md
# Dual-Rate CAN FD Bit Sampler

This block turns an oversampled, asynchronous CAN receive line into a stream of sampled bits. Two bit periods are held: a nominal period for the arbitration and trailing parts of a frame, and a fast period for the data phase. Both periods are given in system-clock samples as fixed-point values with 8 fractional bits. A sample-point fraction says how far into a bit the line is read. The block waits idle for a falling edge, which marks start of frame. From then on it places each sample at a position that is counted from the most recent dominant-going edge. Each later bit moves that position on by one whole period. Every new falling edge re-anchors the count.

A frame parser sits beside the block and watches the strobed bits. When the parser sees a recessive bit-rate-switch bit, it pulses `fast_req`. The block then re-anchors at once and carries on at the fast period. When the parser reaches the CRC delimiter, it pulses `nom_req`, and the bit spacing goes back to nominal. After a run of recessive samples long enough to close a frame, the block drops back to idle at the nominal rate.

Notation used below: P is the active period and O = floor(P*F/256) is the sample offset, with F = `sp_frac`. Both are in 1/256 sample units. With the default 200 MHz clock, 1 Mbit/s nominal and 2 Mbit/s fast give P = 51200 and 25600.

Top module: `can_bit_sampler`

## Requirements
- R1: After reset, `bit_stb` is 0, `bit_idx` is 0 and the block is idle at the nominal rate. While `rx_raw` stays recessive (1), no strobe is issued.
- R2: In idle, a falling edge of `rx_raw` (1 to 0) starts a frame and becomes the anchor. `rx_raw` passes through two synchroniser flops. If the anchoring change happens between rising edges, the strobe for bit k after the anchor is high for exactly one cycle, starting at rising edge number floor((O + k*P)/256) + 3 after the change.
- R3: Inside a frame, every falling edge becomes the new anchor, and k restarts at 0 for the bit that the edge begins.
- R4: `bit_val` is the synchronised line level at the sample point. `bit_idx` is 0 for the first bit of a frame and rises by one per strobe. `bit_idx` changes only together with a strobe.
- R5: A falling edge may reach the sample logic in the same cycle as a sample point. In that case no strobe is issued for that point, and the pending bit is sampled O after the edge.
- R6: Fractional periods build up in fixed point. Each sample position is truncated to a whole sample only when it is compared.
- R7: In a frame, if `fast_req` is high at a rising edge, the fast period becomes active and that edge becomes the anchor. The next strobe starts floor((Pf+Of)/256) rising edges later, and strobes after that are spaced by Pf.
- R8: In a fast-rate frame, if `nom_req` is high at a rising edge, the nominal period becomes active again. The pending sample position moves to the previous sample position plus Pn, and later strobes are spaced by Pn.
- R9: After 11 recessive samples in a row, the block returns to idle at the nominal rate. No further strobes follow, and the next frame begins again at `bit_idx` 0.
- R10: `fast_req` and `nom_req` have no effect while the block is idle. The next frame runs at the nominal period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_raw | input | 1 | Asynchronous receive line, 0 = dominant |
| nom_period | input | 18 | Nominal bit period in samples, 8 fractional bits |
| fast_period | input | 18 | Fast bit period in samples, 8 fractional bits |
| sp_frac | input | 8 | Sample point as a fraction of the period, in 1/256 units |
| fast_req | input | 1 | Parser request: re-anchor and switch to the fast period |
| nom_req | input | 1 | Parser request: return to the nominal period |
| bit_stb | output | 1 | One-cycle strobe at each sample point |
| bit_val | output | 1 | Sampled bit value, valid with the strobe |
| bit_idx | output | 8 | Index of the sampled bit within the frame |

## Verification
A sample point and a resynchronising falling edge can fall in the same cycle. The bench provokes this by ending a recessive bit early, so that its closing falling edge lands exactly on the cycle where the sample point for that bit is due. An independent timing model in the bench predicts the expected strobe list. In that list the colliding sample is absent, and the following dominant bit is sampled one offset after the edge. The run is judged on strobe cycle, value and index. The two rate requests are also driven from the bench in the cycle right after a strobe, to test re-anchoring and rebasing against an accumulated sample position.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    // fixed-point format of periods and sample positions
    localparam int FRAC_W = 8;
    // resolution of the sample-point fraction
    localparam int SPF_W  = 8;

    typedef enum logic {
        MODE_IDLE = 1'b0,
        MODE_RUN  = 1'b1
    } run_mode_e;

endpackage

// File: rtl/cbs_rx_sync.sv
module cbs_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_async,
    output logic rx_sync
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], rx_async};
    end

    // reset to recessive so no false start-of-frame edge appears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign rx_sync = sh_q[STAGES-1];

endmodule

// File: rtl/cbs_phase_calc.sv
module cbs_phase_calc
    import cbs_pkg::*;
#(
    parameter int PW = 18
) (
    input  logic [PW-1:0]    period_i,
    input  logic [SPF_W-1:0] frac_i,
    output logic [PW-1:0]    offset_o
);

    localparam int PRODW = PW + SPF_W;

    logic [PRODW-1:0] prod;

    always_comb begin
        prod     = PRODW'(period_i) * PRODW'(frac_i);
        offset_o = prod[PRODW-1:SPF_W];
    end

endmodule

// File: rtl/cbs_sample_timer.sv
module cbs_sample_timer
    import cbs_pkg::*;
#(
    parameter int PER_INT_W = 10,
    parameter int SPAN_W    = 4,
    parameter int IDX_W     = 8,
    parameter int IDLE_BITS = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_s,
    input  logic [PER_INT_W+FRAC_W-1:0]   per_nom,
    input  logic [PER_INT_W+FRAC_W-1:0]   per_fast,
    input  logic [PER_INT_W+FRAC_W-1:0]   off_nom,
    input  logic [PER_INT_W+FRAC_W-1:0]   off_fast,
    input  logic                          fast_req,
    input  logic                          nom_req,
    output logic                          bit_stb,
    output logic                          bit_val,
    output logic [IDX_W-1:0]              bit_idx
);

    localparam int PW = PER_INT_W + FRAC_W;
    localparam int TW = PW + SPAN_W;
    localparam int EW = PER_INT_W + SPAN_W;
    localparam int RW = $clog2(IDLE_BITS + 1);

    typedef struct packed {
        run_mode_e        mode;
        logic             fast;
        logic [TW-1:0]    target;
        logic [EW-1:0]    elapsed;
        logic [IDX_W-1:0] idx;
        logic [RW-1:0]    run;
        logic             rx_prev;
        logic             stb;
        logic             val;
        logic [IDX_W-1:0] idx_out;
    } tmr_state_t;

    localparam tmr_state_t RST_STATE = '{
        mode: MODE_IDLE, fast: 1'b0, target: '0, elapsed: '0, idx: '0,
        run: '0, rx_prev: 1'b1, stb: 1'b0, val: 1'b1, idx_out: '0
    };

    tmr_state_t s_d, s_q;

    logic          edge_fall;
    logic          in_run;
    logic          hit;
    logic          rate_new;
    logic          closing;
    logic [PW-1:0] per_cur;
    logic [TW-1:0] tgt;
    logic [TW:0]   rebase_sum;
    logic [TW:0]   rebase_diff;

    always_comb begin
        edge_fall   = s_q.rx_prev & ~rx_s;
        in_run      = (s_q.mode == MODE_RUN);
        hit         = in_run && !edge_fall &&
                      (s_q.elapsed == s_q.target[TW-1:FRAC_W]);
        per_cur     = s_q.fast ? per_fast : per_nom;
        rate_new    = fast_req ? 1'b1 : (nom_req ? 1'b0 : s_q.fast);
        closing     = hit && rx_s && (s_q.run == RW'(IDLE_BITS - 1));
        tgt         = s_q.target;
        rebase_sum  = '0;
        rebase_diff = '0;

        s_d         = s_q;
        s_d.stb     = 1'b0;
        s_d.rx_prev = rx_s;
        if (s_q.elapsed != '1) s_d.elapsed = s_q.elapsed + 1'b1;

        if (!in_run) begin
            // requests are ignored while idle
            s_d.fast = 1'b0;
            if (edge_fall) begin
                s_d.mode    = MODE_RUN;
                s_d.elapsed = EW'(1);
                s_d.target  = TW'(off_nom);
                s_d.idx     = '0;
                s_d.run     = '0;
            end
        end else begin
            if (hit) begin
                s_d.stb     = 1'b1;
                s_d.val     = rx_s;
                s_d.idx_out = s_q.idx;
                if (s_q.idx != '1) s_d.idx = s_q.idx + 1'b1;
                s_d.run     = rx_s ? s_q.run + 1'b1 : '0;
            end

            if (edge_fall) begin
                // resync: the bit this edge starts is sampled one offset later
                s_d.fast    = rate_new;
                s_d.elapsed = EW'(1);
                s_d.target  = rate_new ? TW'(off_fast) : TW'(off_nom);
            end else if (fast_req) begin
                // forced anchor at the switch, next bit one fast period on
                s_d.fast    = 1'b1;
                s_d.elapsed = EW'(1);
                s_d.target  = TW'(per_fast) + TW'(off_fast);
            end else begin
                if (hit) tgt = s_q.target + TW'(per_cur);
                if (nom_req && s_q.fast) begin
                    rebase_sum  = {1'b0, tgt} + (TW+1)'(per_nom);
                    if (rebase_sum >= (TW+1)'(per_fast)) begin
                        rebase_diff = rebase_sum - (TW+1)'(per_fast);
                        tgt         = rebase_diff[TW-1:0];
                    end else begin
                        tgt = '0;
                    end
                    s_d.fast = 1'b0;
                end
                s_d.target = tgt;
            end

            if (closing) begin
                s_d.mode = MODE_IDLE;
                s_d.fast = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_STATE;
        else        s_q <= s_d;
    end

    assign bit_stb = s_q.stb;
    assign bit_val = s_q.val;
    assign bit_idx = s_q.idx_out;

    // R1: an idle block that was idle before issues no strobe
    p_no_stb_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_run && $past(!in_run)) |-> !bit_stb);

    // R4: the index output moves only together with a strobe
    p_idx_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_idx) |-> bit_stb);

    // R5: a resync edge in the frame suppresses the strobe of that cycle
    p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && edge_fall) |=> !bit_stb);

    // R7: a fast request re-anchors the count and selects the fast period
    p_fast_anchor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && fast_req && !edge_fall && !closing) |=>
        (s_q.elapsed == EW'(1) && s_q.fast));

    // R9 and R10: idle always runs at the nominal rate
    p_rate_nom_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_run && $past(!in_run)) |-> !s_q.fast);

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
    import cbs_pkg::*;
#(
    parameter int PER_INT_W   = 10,
    parameter int SPAN_W      = 4,
    parameter int IDX_W       = 8,
    parameter int IDLE_BITS   = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_raw,
    input  logic [PER_INT_W+FRAC_W-1:0] nom_period,
    input  logic [PER_INT_W+FRAC_W-1:0] fast_period,
    input  logic [SPF_W-1:0]            sp_frac,
    input  logic                        fast_req,
    input  logic                        nom_req,
    output logic                        bit_stb,
    output logic                        bit_val,
    output logic [IDX_W-1:0]            bit_idx
);

    localparam int PW     = PER_INT_W + FRAC_W;
    localparam int N_RATE = 2;

    logic          rx_s;
    logic [PW-1:0] per_v [N_RATE];
    logic [PW-1:0] off_v [N_RATE];

    assign per_v[0] = nom_period;
    assign per_v[1] = fast_period;

    cbs_rx_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_async (rx_raw),
        .rx_sync  (rx_s)
    );

    for (genvar g = 0; g < N_RATE; g++) begin : g_rate
        cbs_phase_calc #(
            .PW (PW)
        ) u_phase (
            .period_i (per_v[g]),
            .frac_i   (sp_frac),
            .offset_o (off_v[g])
        );
    end

    cbs_sample_timer #(
        .PER_INT_W (PER_INT_W),
        .SPAN_W    (SPAN_W),
        .IDX_W     (IDX_W),
        .IDLE_BITS (IDLE_BITS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_s     (rx_s),
        .per_nom  (per_v[0]),
        .per_fast (per_v[1]),
        .off_nom  (off_v[0]),
        .off_fast (off_v[1]),
        .fast_req (fast_req),
        .nom_req  (nom_req),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .bit_idx  (bit_idx)
    );

endmodule

// File: tb/tb_can_bit_sampler.sv
`timescale 1ns/1ps
module tb_can_bit_sampler;

    localparam int IDLE_N   = 11;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_raw = 1'b1;
    logic [17:0] nom_period = 18'd5120;
    logic [17:0] fast_period = 18'd2560;
    logic [7:0]  sp_frac = 8'd179;
    logic        fast_req = 1'b0;
    logic        nom_req = 1'b0;
    logic        bit_stb;
    logic        bit_val;
    logic [7:0]  bit_idx;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    int fv [64];
    int fl [64];
    int fd [64];
    int fn;

    int lg_cyc [256];
    int lg_val [256];
    int lg_idx [256];
    int lg_n = 0;

    can_bit_sampler dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_raw      (rx_raw),
        .nom_period  (nom_period),
        .fast_period (fast_period),
        .sp_frac     (sp_frac),
        .fast_req    (fast_req),
        .nom_req     (nom_req),
        .bit_stb     (bit_stb),
        .bit_val     (bit_val),
        .bit_idx     (bit_idx)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // strobe logger, sampled away from the active edge
    always @(negedge clk) begin
        if (bit_stb && lg_n < 256) begin
            lg_cyc[lg_n] = cyc;
            lg_val[lg_n] = int'(bit_val);
            lg_idx[lg_n] = int'(bit_idx);
            lg_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int next_fall(input int from);
        for (int j = from; j < fn; j++)
            if (fv[j] == 0 && fv[j-1] == 1) return j;
        return fn;
    endfunction

    function automatic int val_at(input int c);
        for (int j = fn - 1; j >= 0; j--)
            if (fd[j] <= c) return fv[j];
        return 1;
    endfunction

    // drive fv/fl from idle, then compare the log with the timing model
    task automatic run_frame(input string req);
        int base, a, n, ep, h, v, idx, run, ne, off, per;
        int e_cyc [64];
        int e_val [64];
        int e_idx [64];
        base = lg_n;
        per  = int'(nom_period);
        off  = (per * int'(sp_frac)) >>> 8;
        for (int j = 0; j < fn; j++) begin
            @(negedge clk);
            rx_raw = fv[j][0];
            fd[j]  = cyc;
            repeat (fl[j] - 1) @(negedge clk);
        end
        repeat (20) @(negedge clk);

        a = fd[0]; n = 0; ep = next_fall(1); idx = 0; run = 0; ne = 0;
        while (ne < 64) begin
            h = a + 2 + ((off + n * per) >>> 8);
            if (ep < fn && fd[ep] + 2 <= h) begin
                a  = fd[ep];
                n  = 0;
                ep = next_fall(ep + 1);
            end else begin
                v = val_at(h - 2);
                e_cyc[ne] = h + 1;
                e_val[ne] = v;
                e_idx[ne] = idx;
                ne++; idx++; n++;
                run = (v == 1) ? run + 1 : 0;
                if (run == IDLE_N) break;
            end
        end

        chk(lg_n - base == ne, req, "strobe count", lg_n - base, ne);
        for (int k = 0; k < ne && k < lg_n - base; k++) begin
            chk(lg_cyc[base+k] == e_cyc[k], req, "strobe cycle", lg_cyc[base+k], e_cyc[k]);
            chk(lg_val[base+k] == e_val[k], req, "bit value",    lg_val[base+k], e_val[k]);
            chk(lg_idx[base+k] == e_idx[k], req, "bit index",    lg_idx[base+k], e_idx[k]);
        end
    endtask

    task automatic set_pattern(input int len);
        int pat [15] = '{0,1,0,0,1,1,0,1,0,1,1,1,0,0,1};
        fn = 16;
        for (int j = 0; j < 15; j++) begin
            fv[j] = pat[j];
            fl[j] = len;
        end
        fv[15] = 1;
        fl[15] = 400;
    endtask

    task automatic t_reset;
        int base;
        chk(bit_stb == 1'b0, "R1", "strobe after reset", int'(bit_stb), 0);
        chk(bit_idx == 8'd0, "R1", "index after reset", int'(bit_idx), 0);
        base = lg_n;
        repeat (60) @(negedge clk);
        chk(lg_n == base, "R1", "strobes while recessive", lg_n - base, 0);
    endtask

    task automatic t_nominal;
        nom_period = 18'd5120;
        set_pattern(20);
        run_frame("R2 R4 R9");
        // second frame must restart at index 0
        run_frame("R9 R4");
    endtask

    task automatic t_resync;
        set_pattern(21);
        run_frame("R3");
        set_pattern(19);
        run_frame("R3");
    endtask

    task automatic t_collision;
        int vals [6] = '{0,1,0,1,0,1};
        int lens [6] = '{20,13,20,20,20,400};
        nom_period = 18'd5120;
        fn = 6;
        for (int j = 0; j < 6; j++) begin
            fv[j] = vals[j];
            fl[j] = lens[j];
        end
        run_frame("R5");
    endtask

    task automatic t_fraction;
        int vals [13] = '{0,1,1,1,0,1,1,1,1,0,0,1,0};
        nom_period = 18'd2688;   // 10.5 samples
        fn = 14;
        for (int j = 0; j < 13; j++) begin
            fv[j] = vals[j];
            fl[j] = (j % 2 == 0) ? 10 : 11;
        end
        fv[13] = 1;
        fl[13] = 300;
        run_frame("R6");
        nom_period = 18'd5120;
    endtask

    task automatic t_rate_switch;
        int base, r, nq, pf, pn, of;
        int vals [4] = '{0,1,0,1};
        pn = 5120; pf = 2560;
        of = (pf * 179) >>> 8;
        nom_period  = 18'(pn);
        fast_period = 18'(pf);
        base = lg_n;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            rx_raw = vals[j][0];
            if (j < 3) repeat (19) @(negedge clk);
        end
        // wait for the strobe of the rate-switch bit (index 3)
        r = 0;
        for (int w = 0; w < 200; w++) begin
            @(negedge clk);
            if (bit_stb && bit_idx == 8'd3) begin
                r = cyc;
                break;
            end
        end
        chk(r != 0, "R7", "switch bit strobed", r, 1);
        fast_req = 1'b1;
        @(negedge clk);
        fast_req = 1'b0;
        nq = 0;
        for (int w = 0; w < 200; w++) begin
            @(negedge clk);
            if (bit_stb && bit_idx == 8'd5) begin
                nq = cyc;
                break;
            end
        end
        nom_req = 1'b1;
        @(negedge clk);
        nom_req = 1'b0;
        repeat (300) @(negedge clk);

        chk(lg_n - base >= 8, "R7 R8", "strobes in switch frame", lg_n - base, 8);
        if (lg_n - base >= 8) begin
            chk(lg_cyc[base+4] == r + 1 + ((pf + of) >>> 8), "R7",
                "first fast strobe", lg_cyc[base+4], r + 1 + ((pf + of) >>> 8));
            chk(lg_cyc[base+5] == r + 1 + ((2*pf + of) >>> 8), "R7",
                "second fast strobe", lg_cyc[base+5], r + 1 + ((2*pf + of) >>> 8));
            chk(nq == lg_cyc[base+5], "R8", "nominal request cycle", nq, lg_cyc[base+5]);
            chk(lg_cyc[base+6] == r + 1 + ((2*pf + pn + of) >>> 8), "R8",
                "rebased strobe", lg_cyc[base+6], r + 1 + ((2*pf + pn + of) >>> 8));
            chk(lg_cyc[base+7] == r + 1 + ((2*pf + 2*pn + of) >>> 8), "R8",
                "nominal spacing", lg_cyc[base+7], r + 1 + ((2*pf + 2*pn + of) >>> 8));
            chk(lg_val[base+6] == 1, "R8", "rebased value", lg_val[base+6], 1);
            // recessive from index 3 on: idle after index 13
            chk(lg_n - base == 14, "R9", "strobes until idle", lg_n - base, 14);
        end
    endtask

    task automatic t_idle_req;
        @(negedge clk);
        fast_req = 1'b1;
        @(negedge clk);
        fast_req = 1'b0;
        nom_req  = 1'b1;
        @(negedge clk);
        nom_req  = 1'b0;
        fast_req = 1'b1;
        @(negedge clk);
        fast_req = 1'b0;
        repeat (5) @(negedge clk);
        set_pattern(20);
        run_frame("R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_nominal();
        t_resync();
        t_collision();
        t_fraction();
        t_rate_switch();
        t_idle_req();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule